// File: doc/BRIEF.md
# Memory Upset Scanner and Scrubber

This block owns a small block memory and looks after it. After reset it writes the fixed word 0xAAAA into every location. It then reads the memory back over and over, one word per clock, and compares each word with that pattern. For every sweep it counts the words that differ. It also counts the flipped bits, which is the population count of the word XOR the pattern.

When a sweep ends with at least one bad word, the block latches both counts and raises an interrupt to a processor. It then waits for the processor to acknowledge. After the acknowledgment it rewrites every location with the pattern and starts sweeping again. A clean sweep raises nothing, and the next sweep follows at once.

Addresses follow a reflected Gray sequence, so only one address bit toggles from one access to the next. A direct write port lets a test environment plant corrupted words.

Top module: `mem_upset_scrubber`

## Requirements
- R1: While `rst` is high and after it, `irq` is low and both `word_cnt` and `bit_cnt` are zero. The first DEPTH cycles after reset write 0xAAAA into every word before any read.
- R2: Every fill, scan and scrub sweep visits step i at address i ^ (i >> 1), one step per clock. Step i of the first scan after a fill or scrub reads on the (DEPTH+1+i)-th clock edge after the last edge of reset or acknowledgment.
- R3: Each word read during a scan is compared with 0xAAAA. Every mismatching word adds one to the sweep's word count.
- R4: Each word read also adds the number of bits in which it differs from 0xAAAA to the sweep's bit count.
- R5: When a sweep's word count is nonzero, `irq` goes high on the edge right after the one that captured the sweep's last read data. `word_cnt` and `bit_cnt` show that sweep's totals from the same edge.
- R6: A sweep with zero mismatches leaves `irq` low. The first read of the next sweep is issued on the edge right after the last read of the finished one.
- R7: While `irq` is high, it and both counts hold until `scrub_ack` is sampled high. On that edge `irq` falls and a DEPTH-cycle rewrite with 0xAAAA starts, followed by scanning.
- R8: `scrub_ack` has no effect while `irq` is low.
- R9: When `inj_en` is sampled high, `inj_data` is written to `inj_addr` on that edge. A scan read of that address on the same edge returns the old word.
- R10: After `irq` falls, `word_cnt` and `bit_cnt` keep the last reported values until the next report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scrub_ack | input | 1 | Processor acknowledgment of a report |
| inj_en | input | 1 | Direct write strobe for planted corruption |
| inj_addr | input | ADDR_W | Address of the planted word |
| inj_data | input | 16 | Value of the planted word |
| irq | output | 1 | Report pending |
| word_cnt | output | ADDR_W+1 | Mismatching words in the reported sweep |
| bit_cnt | output | clog2(DEPTH*16+1) | Flipped bits in the reported sweep |

## Verification
The bench plants each corrupted word on exactly the edge where the current sweep reads that address. The sweep that is running must therefore stay clean, and the next one must report the plant.

A design that walks addresses in binary order, or that leaves a gap between sweeps, counts some plants one sweep early or raises `irq` on the wrong edge. An acknowledgment pulsed in the middle of a scan must not start a rewrite; a design that obeys it erases the plants and never reports. Vectors mixing multi-bit flips, a rewrite to the pattern value itself, and the final address catch word/bit count confusion and an off-by-one on the last compared word.

// File: rtl/scrub_pkg.sv
`timescale 1ns/1ps
package scrub_pkg;

    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] FILL_WORD = 16'hAAAA;

    typedef enum logic [1:0] {
        ST_FILL,
        ST_SCAN,
        ST_WAIT,
        ST_SCRUB
    } scrub_state_e;

    // tag that travels alongside a read through the memory latency
    typedef struct packed {
        logic valid;
        logic last;
    } rd_tag_t;

    function automatic int unsigned ones_in(input logic [DATA_W-1:0] v);
        int unsigned n;
        n = 0;
        for (int b = 0; b < DATA_W; b++) begin
            n += {31'b0, v[b]};
        end
        return n;
    endfunction

endpackage

// File: rtl/scrub_gray_addr.sv
`timescale 1ns/1ps
module scrub_gray_addr #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [ADDR_W-1:0] bin_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bin_q <= '0;
        end else if (step) begin
            bin_q <= bin_q + 1'b1;
        end
    end

    assign addr = bin_q ^ (bin_q >> 1);
    assign last = &bin_q;

    // R2: consecutive sweep addresses differ in exactly one bit
    a_r2_one_bit_step: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && !$past(clear) && !$past(rst)) |-> ($countones(addr ^ $past(addr)) == 1));

endmodule

// File: rtl/scrub_mem.sv
`timescale 1ns/1ps
module scrub_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        if (re) begin
            rdata <= store[raddr];
        end
    end

endmodule

// File: rtl/scrub_check.sv
`timescale 1ns/1ps
module scrub_check
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BCNT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  rd_tag_t           tag_in,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W:0]   sum_words,
    output logic [BCNT_W-1:0] sum_bits
);
    rd_tag_t           tag_q;
    logic [ADDR_W:0]   acc_w;
    logic [BCNT_W-1:0] acc_b;
    logic [DATA_W-1:0] diff;
    logic              miss;
    logic [BCNT_W-1:0] nbits;

    // align the tag with the one-cycle read latency
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            tag_q <= '0;
        end else begin
            tag_q.valid <= tag_in.valid;
            tag_q.last  <= tag_in.valid && tag_in.last;
        end
    end

    always_comb begin
        diff      = rd_data ^ FILL_WORD;
        miss      = tag_q.valid && (diff != '0);
        nbits     = tag_q.valid ? BCNT_W'(ones_in(diff)) : '0;
        sum_words = acc_w + {{ADDR_W{1'b0}}, miss};
        sum_bits  = acc_b + nbits;
        done      = tag_q.valid && tag_q.last;
    end

    always_ff @(posedge clk) begin
        if (rst || flush || done) begin
            acc_w <= '0;
            acc_b <= '0;
        end else begin
            acc_w <= sum_words;
            acc_b <= sum_bits;
        end
    end

    // R4: every counted word carries at least one flipped bit
    a_r4_bits_cover_words: assert property (@(posedge clk) disable iff (rst)
        {{(BCNT_W > ADDR_W + 1 ? BCNT_W - ADDR_W - 1 : 0){1'b0}}, acc_w} <= acc_b);

endmodule

// File: rtl/mem_upset_scrubber.sv
`timescale 1ns/1ps
module mem_upset_scrubber
    import scrub_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic                                         scrub_ack,
    input  logic                                         inj_en,
    input  logic [ADDR_W-1:0]                            inj_addr,
    input  logic [15:0]                                  inj_data,
    output logic                                         irq,
    output logic [ADDR_W:0]                              word_cnt,
    output logic [$clog2((1 << ADDR_W) * 16 + 1)-1:0]    bit_cnt
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BCNT_W = $clog2(DEPTH * DATA_W + 1);

    scrub_state_e      state_q, state_d;
    logic [ADDR_W-1:0] sweep_addr;
    logic              sweep_last;
    logic              stepping;
    logic              report;
    logic              chk_done;
    logic [ADDR_W:0]   chk_words;
    logic [BCNT_W-1:0] chk_bits;
    logic [ADDR_W:0]   wcnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    rd_tag_t           rd_tag;

    assign stepping = (state_q != ST_WAIT);
    assign report   = chk_done && (chk_words != '0);

    scrub_gray_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst   (rst),
        .clear (report),
        .step  (stepping),
        .addr  (sweep_addr),
        .last  (sweep_last)
    );

    // planted writes take the port over internal pattern writes
    always_comb begin
        wr_en   = inj_en || (state_q == ST_FILL) || (state_q == ST_SCRUB);
        wr_addr = inj_en ? inj_addr : sweep_addr;
        wr_data = inj_en ? inj_data : FILL_WORD;
        rd_tag.valid = (state_q == ST_SCAN);
        rd_tag.last  = sweep_last;
    end

    scrub_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .re    (rd_tag.valid),
        .raddr (sweep_addr),
        .rdata (rd_data)
    );

    scrub_check #(.ADDR_W(ADDR_W), .BCNT_W(BCNT_W)) u_chk (
        .clk       (clk),
        .rst       (rst),
        .flush     (report),
        .tag_in    (rd_tag),
        .rd_data   (rd_data),
        .done      (chk_done),
        .sum_words (chk_words),
        .sum_bits  (chk_bits)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (sweep_last) state_d = ST_SCAN;
            ST_SCAN:  if (report)     state_d = ST_WAIT;
            ST_WAIT:  if (scrub_ack)  state_d = ST_SCRUB;
            ST_SCRUB: if (sweep_last) state_d = ST_SCAN;
            default:                  state_d = ST_FILL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            wcnt_q  <= '0;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (report) begin
                wcnt_q <= chk_words;
                bcnt_q <= chk_bits;
            end
        end
    end

    assign irq      = (state_q == ST_WAIT);
    assign word_cnt = wcnt_q;
    assign bit_cnt  = bcnt_q;

    // R5: a pending report always carries a nonzero word count
    a_r5_irq_has_count: assert property (@(posedge clk) disable iff (rst)
        irq |-> (word_cnt != '0));
    // R3: a sweep cannot count more words than the memory holds
    a_r3_word_bound: assert property (@(posedge clk) disable iff (rst)
        word_cnt <= (ADDR_W + 1)'(DEPTH));
    // R7: report holds until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (irq && !scrub_ack) |=> (irq && $stable(word_cnt) && $stable(bit_cnt)));
    // R7: acknowledgment releases the report
    a_r7_release: assert property (@(posedge clk) disable iff (rst)
        (irq && scrub_ack) |=> !irq);
    // R8: a report only starts out of scanning
    a_r8_rise_from_scan: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(state_q) == ST_SCAN));
    // R10: counts survive the release of the report
    a_r10_counts_kept: assert property (@(posedge clk) disable iff (rst)
        $fell(irq) |-> ($stable(word_cnt) && $stable(bit_cnt)));

endmodule

// File: tb/test_mem_upset_scrubber.sv
`timescale 1ns/1ps
module test_mem_upset_scrubber;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int BCNT_W = $clog2(DEPTH * 16 + 1);
    localparam int NV     = 5;

    // vector table: up to 4 plants (sweep step, value), expected counts, step of a stray ack
    localparam int T_N [NV] = '{1, 2, 4, 4, 4};
    localparam int T_POS [NV][4] = '{
        '{0, 0, 0, 0},
        '{5, 63, 0, 0},
        '{10, 11, 40, 62},
        '{1, 2, 3, 4},
        '{0, 1, 2, 3}
    };
    localparam logic [15:0] T_DATA [NV][4] = '{
        '{16'hAAAB, 16'h0000, 16'h0000, 16'h0000},
        '{16'h5555, 16'hAAA9, 16'h0000, 16'h0000},
        '{16'h0000, 16'hAAAA, 16'hFFFF, 16'h2AAA},
        '{16'hAAAE, 16'hAAAE, 16'hAAAE, 16'hAAAE},
        '{16'h5555, 16'h5555, 16'h5555, 16'h5555}
    };
    localparam int T_EXPW [NV]   = '{1, 2, 3, 4, 4};
    localparam int T_EXPB [NV]   = '{1, 18, 17, 4, 64};
    localparam int T_ACKPOS [NV] = '{-1, -1, -1, 20, 33};

    logic              clk = 1'b0;
    logic              rst;
    logic              scrub_ack;
    logic              inj_en;
    logic [ADDR_W-1:0] inj_addr;
    logic [15:0]       inj_data;
    logic              irq;
    logic [ADDR_W:0]   word_cnt;
    logic [BCNT_W-1:0] bit_cnt;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    mem_upset_scrubber #(.ADDR_W(ADDR_W)) i_mem_upset_scrubber (
        .clk       (clk),
        .rst       (rst),
        .scrub_ack (scrub_ack),
        .inj_en    (inj_en),
        .inj_addr  (inj_addr),
        .inj_data  (inj_data),
        .irq       (irq),
        .word_cnt  (word_cnt),
        .bit_cnt   (bit_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] gray_of(input int i);
        logic [ADDR_W-1:0] b;
        b = ADDR_W'(i);
        return b ^ (b >> 1);
    endfunction

    // caller sits between the anchor edge and the next one
    task automatic run_vector(input int v);
        bit saw_irq;
        logic [ADDR_W:0]   held_w;
        logic [BCNT_W-1:0] held_b;
        saw_irq = 1'b0;
        repeat (DEPTH) @(negedge clk);
        // first scan: plant each word on the edge that reads it (R2, R9)
        for (int i = 0; i < DEPTH; i++) begin
            inj_en    = 1'b0;
            scrub_ack = (i == T_ACKPOS[v]);
            for (int k = 0; k < T_N[v]; k++) begin
                if (T_POS[v][k] == i) begin
                    inj_en   = 1'b1;
                    inj_addr = gray_of(i);
                    inj_data = T_DATA[v][k];
                end
            end
            @(negedge clk);
            if (irq) saw_irq = 1'b1;
        end
        inj_en    = 1'b0;
        scrub_ack = 1'b0;
        check("R6 clean sweep raises no irq", {31'b0, saw_irq}, 0);
        repeat (DEPTH) @(negedge clk);
        check("R5 irq not before last compare", {31'b0, irq}, 0);
        @(negedge clk);
        check("R5 irq on edge after last data", {31'b0, irq}, 1);
        check("R3 word count", 32'(word_cnt), T_EXPW[v]);
        check("R4 bit count", 32'(bit_cnt), T_EXPB[v]);
        held_w = word_cnt;
        held_b = bit_cnt;
        repeat (20) @(negedge clk);
        check("R7 irq holds without ack", {31'b0, irq}, 1);
        check("R7 counts hold without ack", {31'b0, (word_cnt == held_w) && (bit_cnt == held_b)}, 1);
        scrub_ack = 1'b1;
        @(negedge clk);
        scrub_ack = 1'b0;
        check("R7 irq falls after ack", {31'b0, irq}, 0);
        check("R10 word count kept after ack", 32'(word_cnt), T_EXPW[v]);
    endtask

    initial begin
        bit saw_irq;
        rst       = 1'b1;
        scrub_ack = 1'b0;
        inj_en    = 1'b0;
        inj_addr  = '0;
        inj_data  = '0;
        repeat (3) @(negedge clk);
        check("R1 irq low in reset", {31'b0, irq}, 0);
        check("R1 word count zero in reset", 32'(word_cnt), 0);
        check("R1 bit count zero in reset", 32'(bit_cnt), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq low during fill", {31'b0, irq}, 0);
        repeat (DEPTH - 1) @(negedge clk);
        check("R1 word count zero after fill", 32'(word_cnt), 0);
        // realign: one negedge past the last reset edge for the vector walk
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;

        // vector walk; vectors 3 and 4 carry a stray ack during a scan (R8)
        for (int v = 0; v < NV; v++) begin
            run_vector(v);
        end

        // after the final rewrite, memory is clean: no report for several sweeps (R6, R7)
        saw_irq = 1'b0;
        repeat (4 * DEPTH) begin
            @(negedge clk);
            if (irq) saw_irq = 1'b1;
        end
        check("R7 rewrite restores pattern, no further irq", {31'b0, saw_irq}, 0);
        check("R10 counts kept with no new report", 32'(bit_cnt), T_EXPB[NV-1]);
        check("R8 stray ack left counts intact", 32'(word_cnt), T_EXPW[NV-1]);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R7 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule